// File: doc/BRIEF.md
# Four-Bank Word-Interleaved Block Memory

This block is a word-interleaved memory that serves cache-block refills. Storage is split across four banks. The low two bits of a word address pick the bank, and the remaining bits pick the row inside that bank. A block read names four consecutive words. Those words sit in four different banks, so all four bank accesses start in the same cycle and run side by side. Each bank then hands its word to a return sequencer, which puts the words on a one-word response stream in ascending order.

Every bank is a synchronous array with a fixed busy time of `BANK_CYC` cycles, counted by its own timer. A single-word write occupies only the bank it targets. A later block read waits for that one bank and for no other. Requests enter through a one-entry issue stage. It holds the request until every bank the request needs is free, and for reads until the previous block has been fully delivered.

Both edges are valid/ready streams. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a request is held in the issue stage. A response word is consumed on an edge where `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low, the current word and its last flag stay on the bus unchanged.

Top module: `ilv_block_mem`

## Requirements
- R1: During and right after reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A write stores `req_wdata` in bank `req_addr[1:0]` at row `req_addr[ADDR_W-1:2]`. A block read returns the words at base, base+1, base+2 and base+3, in that order.
- R3: For a read, `req_addr[1:0]` is ignored, and the block base is `req_addr` with those two bits cleared.
- R4: The read is accepted on edge t with all banks idle and `rsp_ready` held high. The first word is valid from edge t+11. The four words come on four consecutive cycles, and the last is consumed on edge t+15.
- R5: `rsp_last` is 1 only together with the fourth word of a block.
- R6: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_data` and `rsp_last` hold their values into the next cycle. No word is lost or repeated.
- R7: After a request is accepted, `req_ready` stays 0 until that request starts its bank accesses.
- R8: A write keeps its target bank busy for `BANK_CYC` cycles. A second write to the same bank, accepted 2 cycles after the first, starts only once that bank is free. A third request is therefore accepted 13 cycles after the first. A write to another bank is not delayed.
- R9: A block read starts only when all banks are free and the previous block has been fully delivered. A read accepted 2 cycles after a write shows its first word 22 cycles after the write was accepted.
- R10: A bank never receives a new access while its timer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Issue stage can take a request |
| req_write | input | 1 | 1 = single-word write, 0 = block read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response word present |
| rsp_ready | input | 1 | Consumer takes the response word |
| rsp_data | output | DATA_W | Response word |
| rsp_last | output | 1 | Marks the fourth word of a block |

## Verification
The assertions assume that a word is written before it is read. The bench satisfies this by filling the whole memory first. They also assume that a request, once raised, is not withdrawn before it is taken. The bench raises `req_valid` only in a cycle where it has already seen `req_ready` high, so every request it presents is taken on the next edge. `rsp_ready` is otherwise free: one block is read with the consumer stalling on alternate cycles, to exercise the hold rule.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_st_e;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int ROW_W    = 4,
  parameter int DATA_W   = 32,
  parameter int BANK_CYC = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  output logic              busy,
  output logic              rdy,
  output logic [DATA_W-1:0] rdata
);
  localparam int ROWS = 1 << ROW_W;
  localparam int CW   = $clog2(BANK_CYC + 1);

  logic [DATA_W-1:0] mem [ROWS];
  logic [CW-1:0]     cnt;
  logic              rd_pend;
  logic [ROW_W-1:0]  row_q;
  logic              done_rd;

  assign busy    = (cnt != '0);
  assign done_rd = !start && (cnt == CW'(1)) && rd_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      rd_pend <= 1'b0;
      row_q   <= '0;
      rdy     <= 1'b0;
    end else begin
      if (take) rdy <= 1'b0;
      if (start) begin
        cnt     <= CW'(BANK_CYC);
        rd_pend <= !wr;
        row_q   <= row;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
        if (done_rd) rdy <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (start && wr) mem[row] <= wdata;
    if (done_rd) rdata <= mem[row_q];
  end

  // R10: an access never lands on a bank whose timer still runs
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R8: an access holds the bank busy in the following cycle
  a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/ilv_issue.sv
module ilv_issue #(
  parameter int NBANK  = 4,
  parameter int ROW_W  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [NBANK-1:0]  bank_busy,
  input  logic              seq_idle,
  output logic [NBANK-1:0]  bank_start,
  output logic              rd_fire,
  output logic              iss_wr,
  output logic [ROW_W-1:0]  iss_row,
  output logic [DATA_W-1:0] iss_wdata
);
  localparam int BSEL_W = $clog2(NBANK);

  logic              pend_v;
  logic              pend_wr;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_wdata;
  logic [BSEL_W-1:0] pend_bank;
  logic              can_fire;

  assign pend_bank = pend_addr[BSEL_W-1:0];
  assign req_ready = !pend_v;
  assign can_fire  = pend_v && (pend_wr ? !bank_busy[pend_bank]
                                        : (bank_busy == '0) && seq_idle);
  assign rd_fire   = can_fire && !pend_wr;
  assign iss_wr    = pend_wr;
  assign iss_row   = pend_addr[ADDR_W-1:BSEL_W];
  assign iss_wdata = pend_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v     <= 1'b0;
      pend_wr    <= 1'b0;
      pend_addr  <= '0;
      pend_wdata <= '0;
    end else if (req_valid && req_ready) begin
      pend_v     <= 1'b1;
      pend_wr    <= req_write;
      pend_addr  <= req_addr;
      pend_wdata <= req_wdata;
    end else if (can_fire) begin
      pend_v <= 1'b0;
    end
  end

  for (genvar i = 0; i < NBANK; i++) begin : g_start
    assign bank_start[i] = can_fire && (!pend_wr || pend_bank == BSEL_W'(i));
    // R10: the issue stage only starts free banks
    a_r10_start_free: assert property (@(posedge clk) disable iff (!rst_n)
      bank_start[i] |-> !bank_busy[i]);
  end

  // R7: an accepted request blocks the next one in the following cycle
  a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R8: a write starts exactly one bank
  a_r8_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (can_fire && pend_wr) |-> $onehot0(bank_start) && (bank_start != '0));
endmodule

// File: rtl/ilv_retseq.sv
module ilv_retseq #(
  parameter int NBANK  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_start,
  input  logic [NBANK-1:0]  bank_rdy,
  input  logic [DATA_W-1:0] bank_rdata [NBANK],
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last,
  output logic [NBANK-1:0]  bank_take,
  output logic              idle
);
  import ilv_pkg::*;
  localparam int BSEL_W = $clog2(NBANK);

  seq_st_e           st;
  logic [BSEL_W-1:0] idx;
  logic              fire;

  assign idle      = (st == SEQ_IDLE);
  assign rsp_valid = (st == SEQ_RUN) && bank_rdy[idx];
  assign rsp_data  = bank_rdata[idx];
  assign rsp_last  = rsp_valid && (idx == BSEL_W'(NBANK - 1));
  assign fire      = rsp_valid && rsp_ready;

  for (genvar i = 0; i < NBANK; i++) begin : g_take
    assign bank_take[i] = fire && (idx == BSEL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= SEQ_IDLE;
      idx <= '0;
    end else if (blk_start) begin
      st  <= SEQ_RUN;
      idx <= '0;
    end else if (fire) begin
      if (rsp_last) st <= SEQ_IDLE;
      idx <= idx + 1'b1;
    end
  end

  // R6: a stalled word stays put
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data) && $stable(rsp_last));
  // R5: nothing follows the last word directly
  a_r5_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_last && rsp_ready) |=> !rsp_valid);
  // R9: a new block never starts over an unfinished one
  a_r9_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |-> idle);
endmodule

// File: rtl/ilv_block_mem.sv
module ilv_block_mem #(
  parameter int NBANK    = 4,
  parameter int ROW_W    = 4,
  parameter int DATA_W   = 32,
  parameter int BANK_CYC = 10,
  parameter int ADDR_W   = $clog2(NBANK) + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last
);
  logic [NBANK-1:0]  bank_busy;
  logic [NBANK-1:0]  bank_rdy;
  logic [NBANK-1:0]  bank_take;
  logic [NBANK-1:0]  bank_start;
  logic [DATA_W-1:0] bank_rdata [NBANK];
  logic              rd_fire;
  logic              seq_idle;
  logic              iss_wr;
  logic [ROW_W-1:0]  iss_row;
  logic [DATA_W-1:0] iss_wdata;

  ilv_issue #(.NBANK(NBANK), .ROW_W(ROW_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_issue (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .bank_busy(bank_busy), .seq_idle(seq_idle),
    .bank_start(bank_start), .rd_fire(rd_fire),
    .iss_wr(iss_wr), .iss_row(iss_row), .iss_wdata(iss_wdata)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ilv_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W), .BANK_CYC(BANK_CYC)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .start(bank_start[b]), .wr(iss_wr), .row(iss_row), .wdata(iss_wdata),
      .take(bank_take[b]), .busy(bank_busy[b]), .rdy(bank_rdy[b]),
      .rdata(bank_rdata[b])
    );
  end

  ilv_retseq #(.NBANK(NBANK), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .blk_start(rd_fire), .bank_rdy(bank_rdy), .bank_rdata(bank_rdata),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_last(rsp_last), .bank_take(bank_take), .idle(seq_idle)
  );

  // R1: no response can exist without an earlier request
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid && req_ready);
endmodule

// File: tb/tb_ilv_block_mem.sv
`timescale 1ns/1ps
module tb_ilv_block_mem;
  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic          rsp_last;

  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ilv_block_mem dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_last(rsp_last)
  );

  // read vectors: {request address, expected block base}
  localparam logic [11:0] RD_VEC [6] = '{
    {6'd0,  6'd0}, {6'd5,  6'd4},  {6'd14, 6'd12},
    {6'd63, 6'd60}, {6'd32, 6'd32}, {6'd18, 6'd16}
  };

  function automatic logic [31:0] pat(input logic [5:0] a);
    return {16'hC0DE, 10'd0, a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input bit w, input logic [5:0] a, input logic [31:0] d,
                      output int t);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    t = cyc;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_blk(input logic [5:0] a, input bit stall, output int t_acc,
                        output int t_first, output int t_last,
                        output logic [31:0] w [4], output logic [3:0] lastv);
    int n = 0;
    bit held = 1'b0;
    logic [31:0] hd = '0;
    send(1'b0, a, '0, t_acc);
    t_first = 0; t_last = 0; lastv = '0;
    while (n < 4) begin
      rsp_ready = stall ? (cyc % 2 == 1) : 1'b1;
      if (held)
        chk(rsp_valid && rsp_data == hd, "R6 hold", rsp_data, hd);
      held = rsp_valid && !rsp_ready;
      hd = rsp_data;
      if (rsp_valid && rsp_ready) begin
        if (n == 0) t_first = cyc;
        t_last = cyc;
        w[n] = rsp_data;
        lastv[n] = rsp_last;
        n++;
      end
      @(negedge clk);
    end
    rsp_ready = 1'b1;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t0, t1, t2, t3, ta, tf, tl;
    logic [31:0] w [4];
    logic [3:0]  lv;

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 valid in reset", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 after reset",
        {30'd0, req_ready, rsp_valid}, 32'd2);

    for (int a = 0; a < 64; a++) send(1'b1, 6'(a), pat(6'(a)), t0);
    repeat (12) @(negedge clk);

    // R2 R3 R4 R5: table of block reads
    for (int i = 0; i < 6; i++) begin
      logic [5:0] base;
      base = RD_VEC[i][5:0];
      rd_blk(RD_VEC[i][11:6], 1'b0, ta, tf, tl, w, lv);
      for (int k = 0; k < 4; k++)
        chk(w[k] == pat(base + 6'(k)), "R2 R3 word", w[k], pat(base + 6'(k)));
      chk(tf - ta == 11, "R4 first word", 32'(tf - ta), 11);
      chk(tl - ta == 14, "R4 last word", 32'(tl - ta), 14);
      chk(lv == 4'b1000, "R5 last flag", 32'(lv), 32'h8);
    end

    // R6: consumer stalls on alternate cycles
    rd_blk(6'd8, 1'b1, ta, tf, tl, w, lv);
    for (int k = 0; k < 4; k++)
      chk(w[k] == pat(6'd8 + 6'(k)), "R6 word order", w[k], pat(6'd8 + 6'(k)));
    chk(lv == 4'b1000, "R6 R5 last flag", 32'(lv), 32'h8);

    // R8 R7: same-bank writes wait, other-bank writes do not
    repeat (12) @(negedge clk);
    send(1'b1, 6'd20, 32'h1111_0001, t0);
    send(1'b1, 6'd24, 32'h2222_0002, t1);
    chk(t1 - t0 == 2, "R8 second accept", 32'(t1 - t0), 2);
    chk(req_ready == 1'b0, "R7 held while bank busy", 32'(req_ready), 0);
    send(1'b1, 6'd21, 32'h3333_0003, t2);
    chk(t2 - t0 == 13, "R8 same bank wait", 32'(t2 - t0), 13);
    send(1'b1, 6'd30, 32'h4444_0004, t3);
    send(1'b1, 6'd31, 32'h5555_0005, t1);
    chk(t1 - t3 == 2, "R8 other bank no wait", 32'(t1 - t3), 2);
    repeat (14) @(negedge clk);
    rd_blk(6'd20, 1'b0, ta, tf, tl, w, lv);
    chk(w[0] == 32'h1111_0001, "R2 written word", w[0], 32'h1111_0001);
    chk(w[1] == 32'h3333_0003, "R2 written word", w[1], 32'h3333_0003);
    chk(w[2] == pat(6'd22), "R2 untouched word", w[2], pat(6'd22));
    rd_blk(6'd24, 1'b0, ta, tf, tl, w, lv);
    chk(w[0] == 32'h2222_0002, "R8 delayed write landed", w[0], 32'h2222_0002);

    // R9: read waits for the one bank a write occupies
    repeat (12) @(negedge clk);
    send(1'b1, 6'd40, 32'h6666_0006, t0);
    rd_blk(6'd40, 1'b0, ta, tf, tl, w, lv);
    chk(ta - t0 == 2, "R9 read accepted", 32'(ta - t0), 2);
    chk(tf - t0 == 22, "R9 read after write", 32'(tf - t0), 22);
    chk(w[0] == 32'h6666_0006, "R9 fresh data", w[0], 32'h6666_0006);
    chk(w[3] == pat(6'd43), "R9 other banks", w[3], pat(6'd43));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule